// File: doc/BRIEF.md
# Push-Multiple Decoder and Store Sequencer

This block takes one push-type instruction word and turns it into a burst of stack stores. The word comes from either the 32-bit fixed-width instruction set or the mixed 16/32-bit compact set. A mode input says which set the word belongs to. The block recognises five encodings and builds a 16-bit register mask from the matched one. It then sorts the word into one of three outcomes: a valid push, an undefined encoding, or a word that must go back to the generic decrement-before store-multiple path.

For a valid push, the block reads each selected register through a register-file read port. It writes the registers as a descending full-stack block, so the highest stored word sits just below the stack pointer. It moves one word per cycle when memory is ready, then writes the new stack pointer back once.

Undefined words and redirected words raise a one-cycle flag. They cause no memory or stack-pointer activity. The block accepts a new word only while it is idle.

Top module: `pushseq_top`

## Requirements
- R1: In compact mode (`ins_compact`=1) the first halfword sits in `ins_word[31:16]` and the second in `ins_word[15:0]`. A first halfword with bits [15:9]=1011010 is the 16-bit form. Its mask is bit 14 = halfword bit 8, bits [7:0] = halfword bits [7:0], and all other mask bits zero.
- R2: The 16-bit compact form is undefined when its mask is all zeros.
- R3: A compact word with first halfword 0xE8AD is the multi-register wide form. Its mask takes bit 14 from second-halfword bit 14 and bits [12:0] from second-halfword bits [12:0]. Mask bits 15 and 13 are zero whatever the word holds. The form is undefined when fewer than two mask bits are set.
- R4: A compact word with first halfword 0xF84D and second-halfword bits [11:0]=0xD04 is the single-register wide form. Its mask has only bit Rt set, where Rt is second-halfword bits [15:12]. It is undefined when Rt is 13 or 15.
- R5: In fixed-width mode (`ins_compact`=0), bits [27:16]=0x92D select the multi-register form, with the mask taken directly from bits [15:0]. Bits [31:28] are ignored. If fewer than two mask bits are set, the word is redirected: it raises `redirect_pulse` and is not executed.
- R6: In fixed-width mode, bits [27:16]=0x52D together with bits [11:0]=0x004 select the single-register form, with Rt in bits [15:12]. It is undefined when Rt is 13.
- R7: A push of n registers stores them at consecutive word addresses from SP-4n up to SP-4, in ascending register order. The lowest-numbered register goes to the lowest address. Each store carries the register-file value of that register.
- R8: A store beat completes only in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr` and `rf_addr` hold steady.
- R9: `sp_we` pulses for exactly one cycle, in the cycle after the last store is accepted. `sp_wdata` then equals SP-4n.
- R10: An undefined word raises `undef_pulse` for one cycle, in the cycle after the word is accepted. A word matching none of the five forms counts as undefined. Undefined and redirected words cause no store and no stack-pointer write.
- R11: `ins_ready` is high exactly when the block is idle. A word offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block idle, word accepted this cycle if valid |
| ins_compact | input | 1 | 1 = compact instruction set, 0 = fixed-width set |
| ins_word | input | 32 | Instruction word (compact: first halfword in upper half) |
| sp_cur | input | ADDR_W | Current stack pointer, sampled on acceptance |
| rf_addr | output | 4 | Register-file read index |
| rf_data | input | DATA_W | Register-file read data |
| mem_valid | output | 1 | Store beat requested |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Store address |
| mem_data | output | DATA_W | Store data |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | ADDR_W | New stack pointer |
| undef_pulse | output | 1 | Undefined encoding flag |
| redirect_pulse | output | 1 | Pass-on-to-store-multiple flag |

## Verification
The flag for one word and the acceptance of the next word can fall in the same cycle. After an undefined or redirected word, the block is idle again at once. So the bench offers the next word in the very cycle the flag is high, for example a zero-mask 16-bit word followed straight away by a valid push. The check requires that the flag lasts one cycle and adds no store, and that the following push still yields exactly its expected store burst and stack-pointer write. Stalled memory cycles are mixed into some pushes to show the burst holding steady across them.

// File: rtl/pushseq_pkg.sv
`timescale 1ns/1ps
package pushseq_pkg;

    localparam int REG_COUNT = 16;
    localparam int REG_IW    = 4;
    localparam int CNT_W     = 5;

    // opcode constants
    localparam logic [6:0]  C16_OP   = 7'b1011010;
    localparam logic [15:0] CMUL_HW1 = 16'hE8AD;
    localparam logic [15:0] CSIN_HW1 = 16'hF84D;
    localparam logic [11:0] CSIN_LOW = 12'hD04;
    localparam logic [11:0] FMUL_OP  = 12'h92D;
    localparam logic [11:0] FSIN_OP  = 12'h52D;
    localparam logic [11:0] FSIN_LOW = 12'h004;
    localparam logic [3:0]  SP_IDX   = 4'd13;
    localparam logic [3:0]  PC_IDX   = 4'd15;

    typedef enum logic [1:0] {
        V_PUSH     = 2'd0,
        V_UNDEF    = 2'd1,
        V_REDIRECT = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_WB    = 2'd2
    } state_e;

    typedef struct packed {
        verdict_e               verdict;
        logic [REG_COUNT-1:0]   mask;
        logic [CNT_W-1:0]       count;
    } dec_t;

    function automatic logic [CNT_W-1:0] popcnt(input logic [REG_COUNT-1:0] m);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            c = c + CNT_W'(m[i]);
        end
        return c;
    endfunction

    function automatic logic [REG_COUNT-1:0] one_reg(input logic [REG_IW-1:0] r);
        logic [REG_COUNT-1:0] m;
        m = '0;
        m[r] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pushseq_decode.sv
`timescale 1ns/1ps
module pushseq_decode
    import pushseq_pkg::*;
(
    input  logic        compact,
    input  logic [31:0] word,
    output dec_t        dec
);

    logic [15:0] hw1;
    logic [15:0] hw2;
    logic        hit_c16, hit_cmul, hit_csin, hit_fmul, hit_fsin;
    logic [REG_COUNT-1:0] m_c16, m_cmul, m_csin, m_fmul, m_fsin;
    logic [REG_IW-1:0]    rt_c, rt_f;

    assign hw1 = word[31:16];
    assign hw2 = word[15:0];
    assign rt_c = hw2[15:12];
    assign rt_f = word[15:12];

    assign hit_c16  = (hw1[15:9] == C16_OP);
    assign hit_cmul = (hw1 == CMUL_HW1);
    assign hit_csin = (hw1 == CSIN_HW1) && (hw2[11:0] == CSIN_LOW);
    assign hit_fmul = (word[27:16] == FMUL_OP);
    assign hit_fsin = (word[27:16] == FSIN_OP) && (word[11:0] == FSIN_LOW);

    assign m_c16  = {1'b0, hw1[8], 6'b000000, hw1[7:0]};
    assign m_cmul = {1'b0, hw2[14], 1'b0, hw2[12:0]};
    assign m_csin = one_reg(rt_c);
    assign m_fmul = word[15:0];
    assign m_fsin = one_reg(rt_f);

    always_comb begin
        logic [REG_COUNT-1:0] m;
        logic [CNT_W-1:0]     n;
        verdict_e             v;
        m = '0;
        v = V_UNDEF;
        if (compact) begin
            if (hit_c16) begin
                m = m_c16;
                v = (popcnt(m_c16) == '0) ? V_UNDEF : V_PUSH;
            end else if (hit_cmul) begin
                m = m_cmul;
                v = (popcnt(m_cmul) < CNT_W'(2)) ? V_UNDEF : V_PUSH;
            end else if (hit_csin) begin
                m = m_csin;
                v = (rt_c == SP_IDX || rt_c == PC_IDX) ? V_UNDEF : V_PUSH;
            end
        end else begin
            if (hit_fmul) begin
                m = m_fmul;
                v = (popcnt(m_fmul) < CNT_W'(2)) ? V_REDIRECT : V_PUSH;
            end else if (hit_fsin) begin
                m = m_fsin;
                v = (rt_f == SP_IDX) ? V_UNDEF : V_PUSH;
            end
        end
        n = popcnt(m);
        dec.verdict = v;
        dec.mask    = m;
        dec.count   = n;
    end

endmodule

// File: rtl/pushseq_pick.sv
`timescale 1ns/1ps
module pushseq_pick #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);

    logic [N-1:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g] = req[g] & ~seen[g];
        if (g < N - 1) begin : g_next
            assign seen[g+1] = seen[g] | req[g];
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/pushseq_seq.sv
`timescale 1ns/1ps
module pushseq_seq
    import pushseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] sp_cur,
    output logic [REG_IW-1:0] rf_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_wdata,
    output logic              undef_pulse,
    output logic              redirect_pulse
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    state_e               state;
    logic [REG_COUNT-1:0] rem_mask;
    logic [REG_COUNT-1:0] grant;
    logic [REG_IW-1:0]    cur_idx;
    logic [ADDR_W-1:0]    cur_addr;
    logic [ADDR_W-1:0]    base_addr;
    logic [ADDR_W-1:0]    start_addr;
    logic                 accept;
    logic                 beat;
    logic                 last_beat;

    pushseq_pick #(.N(REG_COUNT)) u_pick (
        .req   (rem_mask),
        .grant (grant),
        .idx   (cur_idx)
    );

    assign ins_ready  = (state == ST_IDLE);
    assign accept     = ins_valid && ins_ready;
    assign start_addr = sp_cur - (ADDR_W'(dec.count) * STEP);
    assign beat       = (state == ST_STORE) && mem_ready;
    assign last_beat  = ~|(rem_mask & ~grant);

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            rem_mask       <= '0;
            cur_addr       <= '0;
            base_addr      <= '0;
            undef_pulse    <= 1'b0;
            redirect_pulse <= 1'b0;
        end else begin
            undef_pulse    <= 1'b0;
            redirect_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        case (dec.verdict)
                            V_PUSH: begin
                                rem_mask  <= dec.mask;
                                cur_addr  <= start_addr;
                                base_addr <= start_addr;
                                state     <= ST_STORE;
                            end
                            V_REDIRECT: redirect_pulse <= 1'b1;
                            default:    undef_pulse    <= 1'b1;
                        endcase
                    end
                end
                ST_STORE: begin
                    if (beat) begin
                        rem_mask <= rem_mask & ~grant;
                        cur_addr <= cur_addr + STEP;
                        if (last_beat) state <= ST_WB;
                    end
                end
                ST_WB: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rf_addr   = cur_idx;
    assign mem_valid = (state == ST_STORE);
    assign mem_addr  = cur_addr;
    assign sp_we     = (state == ST_WB);
    assign sp_wdata  = base_addr;

endmodule

// File: rtl/pushseq_top.sv
`timescale 1ns/1ps
module pushseq_top
    import pushseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic              ins_compact,
    input  logic [31:0]       ins_word,
    input  logic [ADDR_W-1:0] sp_cur,
    output logic [3:0]        rf_addr,
    input  logic [DATA_W-1:0] rf_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_wdata,
    output logic              undef_pulse,
    output logic              redirect_pulse
);

    dec_t dec;

    pushseq_decode u_dec (
        .compact (ins_compact),
        .word    (ins_word),
        .dec     (dec)
    );

    pushseq_seq #(
        .ADDR_W     (ADDR_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .ins_valid      (ins_valid),
        .ins_ready      (ins_ready),
        .dec            (dec),
        .sp_cur         (sp_cur),
        .rf_addr        (rf_addr),
        .mem_valid      (mem_valid),
        .mem_ready      (mem_ready),
        .mem_addr       (mem_addr),
        .sp_we          (sp_we),
        .sp_wdata       (sp_wdata),
        .undef_pulse    (undef_pulse),
        .redirect_pulse (redirect_pulse)
    );

    assign mem_data = rf_data;

endmodule

// File: rtl/pushseq_check.sv
`timescale 1ns/1ps
module pushseq_check #(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [3:0]        rf_addr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sp_we,
    input logic              undef_pulse,
    input logic              redirect_pulse
);

    // R8: stalled beat holds address and register index
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(rf_addr)));

    // R7: consecutive beats climb by one word
    p_walk_up_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(STEP_BYTES)));

    // R9: write-back follows an accepted store and lasts one cycle
    p_sp_after_store_r9: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> $past(mem_valid && mem_ready));
    p_sp_single_r9: assert property (@(posedge clk) disable iff (rst)
        sp_we |=> !sp_we);

    // R10: flags come from an accepted word and never coexist with stores
    p_flag_source_r10: assert property (@(posedge clk) disable iff (rst)
        (undef_pulse || redirect_pulse) |-> $past(ins_valid && ins_ready));
    p_flag_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (undef_pulse || redirect_pulse) |-> (!mem_valid && !sp_we && !(undef_pulse && redirect_pulse)));

    // R11: ready only while nothing is in flight
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        ins_ready |-> (!mem_valid && !sp_we));

endmodule

bind pushseq_top pushseq_check #(
    .ADDR_W     (ADDR_W),
    .STEP_BYTES (STEP_BYTES)
) u_check (
    .clk            (clk),
    .rst            (rst),
    .ins_valid      (ins_valid),
    .ins_ready      (ins_ready),
    .rf_addr        (rf_addr),
    .mem_valid      (mem_valid),
    .mem_ready      (mem_ready),
    .mem_addr       (mem_addr),
    .sp_we          (sp_we),
    .undef_pulse    (undef_pulse),
    .redirect_pulse (redirect_pulse)
);

// File: tb/pushseq_top_test.sv
`timescale 1ns/1ps
module pushseq_top_test;

    localparam int K_PUSH = 0;
    localparam int K_UNDEF = 1;
    localparam int K_REDIR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic        ins_compact = 1'b0;
    logic [31:0] ins_word = '0;
    logic [31:0] sp_cur = '0;
    logic [3:0]  rf_addr;
    logic [31:0] rf_data;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        sp_we;
    logic [31:0] sp_wdata;
    logic        undef_pulse;
    logic        redirect_pulse;

    int checks = 0;
    int fails = 0;
    bit stall_mode = 1'b0;
    bit expect_sp = 1'b0;
    int cyc = 0;

    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    bit          q_last[$];
    logic [31:0] q_sp[$];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] regval(input logic [3:0] i);
        return 32'hD00D_0000 + {28'h0, i} * 32'h0101;
    endfunction

    assign rf_data = regval(rf_addr);

    pushseq_top uut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_compact(ins_compact), .ins_word(ins_word), .sp_cur(sp_cur),
        .rf_addr(rf_addr), .rf_data(rf_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .undef_pulse(undef_pulse),
        .redirect_pulse(redirect_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory ready pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            mem_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
        end
    end

    // monitor: pops expected beats and write-backs
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (expect_sp) begin
                    chk(sp_we == 1'b1 && q_sp.size() > 0 && sp_wdata == q_sp[0],
                        "R9 sp write-back", sp_wdata, (q_sp.size() > 0) ? q_sp[0] : 32'hx);
                    if (q_sp.size() > 0) void'(q_sp.pop_front());
                    expect_sp = 1'b0;
                end else if (sp_we) begin
                    chk(1'b0, "R10 unexpected sp write", sp_wdata, 32'h0);
                end
                if (mem_valid) begin
                    if (q_addr.size() == 0) begin
                        chk(1'b0, "R10 unexpected store", mem_addr, 32'h0);
                    end else begin
                        chk(mem_addr == q_addr[0], "R7 store address", mem_addr, q_addr[0]);
                        chk(mem_data == q_data[0], "R7 store data", mem_data, q_data[0]);
                        chk(!ins_ready, "R11 busy during store", {31'h0, ins_ready}, 32'h0);
                        if (mem_ready) begin
                            if (q_last[0]) expect_sp = 1'b1;
                            void'(q_addr.pop_front());
                            void'(q_data.pop_front());
                            void'(q_last.pop_front());
                        end
                    end
                end
            end
        end
    end

    // expected burst from mask and stack pointer
    task automatic expect_push(input logic [15:0] mask, input logic [31:0] sp);
        int n = 0;
        int k = 0;
        logic [31:0] a;
        for (int i = 0; i < 16; i++) if (mask[i]) n++;
        a = sp - 32'(4 * n);
        q_sp.push_back(a);
        for (int i = 0; i < 16; i++) begin
            if (mask[i]) begin
                k++;
                q_addr.push_back(a);
                q_data.push_back(regval(4'(i)));
                q_last.push_back(k == n);
                a = a + 32'd4;
            end
        end
    endtask

    // driver: called at a negedge, returns at the negedge after acceptance
    task automatic send(input bit compact, input logic [31:0] word, input logic [31:0] sp,
                        input int kind, input logic [15:0] mask, input string req);
        while (!ins_ready) @(negedge clk);
        if (kind == K_PUSH) expect_push(mask, sp);
        ins_compact = compact;
        ins_word    = word;
        sp_cur      = sp;
        ins_valid   = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(undef_pulse == (kind == K_UNDEF), {req, " undef flag"}, {31'h0, undef_pulse}, 32'(kind == K_UNDEF));
        chk(redirect_pulse == (kind == K_REDIR), {req, " redirect flag"}, {31'h0, redirect_pulse}, 32'(kind == K_REDIR));
        if (kind == K_PUSH)
            chk(!ins_ready, {req, " R11 busy after accept"}, {31'h0, ins_ready}, 32'h0);
    endtask

    task automatic drain();
        while (!(ins_ready && q_addr.size() == 0 && !expect_sp && q_sp.size() == 0)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ins_ready == 1'b1, "R11 reset ready", {31'h0, ins_ready}, 32'h1);
        chk(mem_valid == 1'b0 && sp_we == 1'b0, "R11 reset quiet", {30'h0, mem_valid, sp_we}, 32'h0);
        chk(undef_pulse == 1'b0 && redirect_pulse == 1'b0, "R10 reset flags",
            {30'h0, undef_pulse, redirect_pulse}, 32'h0);

        // R1: 16-bit compact, M plus r0 and r2
        send(1'b1, 32'hB505_0000, 32'h0000_1000, K_PUSH, 16'h4005, "R1");
        // R11: word offered while busy is ignored
        ins_compact = 1'b1; ins_word = 32'hB400_0000; ins_valid = 1'b1;
        @(negedge clk);
        chk(!undef_pulse, "R11 busy word ignored", {31'h0, undef_pulse}, 32'h0);
        ins_valid = 1'b0;
        drain();

        // R2 then R1 back-to-back: flag cycle coincides with next acceptance
        send(1'b1, 32'hB400_0000, 32'h0000_2000, K_UNDEF, 16'h0, "R2");
        send(1'b1, 32'hB500_0000, 32'h0000_2000, K_PUSH, 16'h4000, "R1 M only");
        drain();

        // R3: wide multi; bits 15 and 13 of list dropped
        send(1'b1, 32'hE8AD_E803, 32'h0000_3000, K_PUSH, 16'h4803, "R3");
        drain();
        send(1'b1, 32'hE8AD_0010, 32'h0000_3000, K_UNDEF, 16'h0, "R3 one reg");
        send(1'b1, 32'hE8AD_A000, 32'h0000_3000, K_UNDEF, 16'h0, "R3 forced zeros");

        // R4: wide single
        send(1'b1, 32'hF84D_5D04, 32'h0000_4000, K_PUSH, 16'h0020, "R4");
        drain();
        send(1'b1, 32'hF84D_DD04, 32'h0000_4000, K_UNDEF, 16'h0, "R4 rt13");
        send(1'b1, 32'hF84D_FD04, 32'h0000_4000, K_UNDEF, 16'h0, "R4 rt15");

        // R5: fixed multi, condition field ignored
        send(1'b0, 32'h192D_8011, 32'h0000_5000, K_PUSH, 16'h8011, "R5");
        drain();
        send(1'b0, 32'hE92D_0040, 32'h0000_5000, K_REDIR, 16'h0, "R5 one reg");
        send(1'b0, 32'hE92D_0000, 32'h0000_5000, K_REDIR, 16'h0, "R5 empty");
        send(1'b1, 32'hB501_0000, 32'h0000_5100, K_PUSH, 16'h4001, "R5 then push");
        drain();

        // R6: fixed single
        send(1'b0, 32'hE52D_F004, 32'h0000_6000, K_PUSH, 16'h8000, "R6");
        drain();
        send(1'b0, 32'hE52D_D004, 32'h0000_6000, K_UNDEF, 16'h0, "R6 rt13");

        // R10: words matching no form
        send(1'b0, 32'hE52D_3008, 32'h0000_6000, K_UNDEF, 16'h0, "R10 no match fixed");
        send(1'b1, 32'hF84D_5D05, 32'h0000_6000, K_UNDEF, 16'h0, "R10 no match compact");
        send(1'b0, 32'hB505_0000, 32'h0000_6000, K_UNDEF, 16'h0, "R10 compact word in fixed mode");

        // R8: stalled memory
        stall_mode = 1'b1;
        send(1'b1, 32'hE8AD_5FFF, 32'h0001_0000, K_PUSH, 16'h5FFF, "R8 stalled wide");
        drain();
        send(1'b0, 32'hE92D_FFFF, 32'h0002_0000, K_PUSH, 16'hFFFF, "R8 stalled full");
        drain();
        stall_mode = 1'b0;

        chk(q_addr.size() == 0 && q_sp.size() == 0, "R7 all stores seen",
            32'(q_addr.size() + q_sp.size()), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule